// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programmable state of an interrupt router. It has a device identifier, a read-only version word and one 64-bit redirection entry for each interrupt pin. Software cannot address any of it directly. It first writes an index into a select register, then reads or writes the chosen 32-bit word through a data window. Each redirection entry takes two indices: an even one for the low word and an odd one for the high word.

Every entry is exported at all times as a flat vector, so the trigger and delivery logic sees every pin's fields in parallel. When an entry write lands on a pin that the trigger logic reports as pending, the block raises a one-cycle service request naming that pin. When a write flips a pin's mask bit, the block pulses a mask-change strobe with the pin and the new mask value. The remote-IRR bit of each entry cannot be written from the bus. The trigger logic sets and clears it through a per-pin port, and any write to an entry's low word clears it.

Top module: `redir_regfile`

## Requirements
- R1: A write to bus offset 0x00 stores the 32-bit index. A read of offset 0x00 returns that index, and a read of any offset other than 0x00 and 0x10 returns zero. Read data appears on `busRdata` one clock after the cycle in which `busRdEn` is high.
- R2: Index 0x00 is the identifier word. A window write (offset 0x10) stores data bits 27:24 as the 4-bit identifier. A read returns the identifier in bits 27:24 and zeros in all other bits.
- R3: Index 0x01 reads as (NUM_PINS-1) in bits 23:16 and VERSION in bits 7:0, which is 0x00170011 with the default parameters. Window writes to it change nothing.
- R4: Index 0x02 reads the same identifier in bits 27:24. Window writes to it leave the identifier unchanged.
- R5: An index of 0x10 or above selects entry (index-0x10)>>1. An even index selects entry bits 31:0 and an odd index selects bits 63:32. A window write to an entry number at or beyond NUM_PINS changes no entry. Reads of indices 0x03..0x0F, or of entries out of range, return zero.
- R6: A window write to an entry's low word forces that entry's remote-IRR bit (bit 14) to 0, whatever the written data. A write to the high word leaves the bit as it was.
- R7: After a window write to an entry whose pin has `pendingIn` high in the write cycle, `svcValid` is high for exactly one cycle, on the clock after the write, and `svcPin` holds the pin number. Otherwise `svcValid` stays low.
- R8: After reset the select register and the identifier are zero, and every entry equals 0x0000_0000_0001_0000, meaning only the mask bit (bit 16) is set.
- R9: Bus writes with `busBytes` other than 4 or 8 are ignored at both offsets. With 4 or 8, the low 32 bits of `busWdata` are used.
- R10: `rirrSet[i]` sets and `rirrClr[i]` clears entry i's bit 14 at the next clock. Clear wins over set, and a low-word write to the same entry in the same cycle wins over both.
- R11: When a low-word write changes an entry's mask bit (bit 16), `maskChgValid` pulses one cycle after the write, with `maskChgPin` holding the pin and `maskChgVal` holding the new mask value.
- R12: `entryFlat[64*i +: 64]` is entry i. Its fields are vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14, trigger mode 15 (1 = level), mask 16 and destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Bus write request |
| busRdEn | input | 1 | Bus read request |
| busAddr | input | 8 | Bus offset (0x00 select, 0x10 window) |
| busBytes | input | 4 | Access size in bytes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pendingIn | input | NUM_PINS | Pending state of each pin, from the trigger logic |
| rirrSet | input | NUM_PINS | Per-pin remote-IRR set |
| rirrClr | input | NUM_PINS | Per-pin remote-IRR clear |
| entryFlat | output | NUM_PINS*64 | All redirection entries |
| svcValid | output | 1 | Service request pulse |
| svcPin | output | PIN_W | Pin to service |
| maskChgValid | output | 1 | Mask-change pulse |
| maskChgPin | output | PIN_W | Pin whose mask changed |
| maskChgVal | output | 1 | New mask value |

## Verification
Register state, the exported entries and the remote-IRR bits change at the first clock edge after the request. The read word, the service request and the mask strobe are registered, so all of them appear one clock after the request cycle. Each bus task in the bench drives its request at a falling edge, drops it at the next falling edge and samples there. That sampling point is after exactly one rising edge, so the registered pulses are observed in the only cycle in which they are high. Remote-IRR port stimulus follows the same one-edge rule, with `entryFlat` sampled at the following falling edge.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam logic [7:0]  OFS_SELECT = 8'h00;
  localparam logic [7:0]  OFS_WINDOW = 8'h10;
  localparam logic [31:0] IDX_ID     = 32'h00;
  localparam logic [31:0] IDX_VER    = 32'h01;
  localparam logic [31:0] IDX_ARB    = 32'h02;
  localparam logic [31:0] IDX_TABLE  = 32'h10;
  localparam int          RIRR_BIT   = 14;
  localparam int          MASK_BIT   = 16;

  typedef struct packed {
    logic        selWr;
    logic        idWr;
    logic        entWr;
    logic        entHi;
    logic [7:0]  entIdx;
    logic [31:0] wdata;
  } redirStrobe_t;
endpackage

// File: rtl/redir_ctrl.sv
module redir_ctrl
  import redir_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic         busWrEn,
  input  logic [7:0]   busAddr,
  input  logic [3:0]   busBytes,
  input  logic [31:0]  busWdata,
  input  logic [31:0]  selReg,
  output redirStrobe_t strobe
);
  logic        sizeOk;
  logic        winWr;
  logic [31:0] tblOfs;
  logic [31:0] entFull;
  logic        inTable;

  always_comb begin
    sizeOk  = (busBytes == 4'd4) || (busBytes == 4'd8);
    winWr   = busWrEn && sizeOk && (busAddr == OFS_WINDOW);
    tblOfs  = selReg - IDX_TABLE;
    entFull = tblOfs >> 1;
    inTable = (selReg >= IDX_TABLE) && (entFull < 32'(NUM_PINS));

    strobe.selWr  = busWrEn && sizeOk && (busAddr == OFS_SELECT);
    strobe.idWr   = winWr && (selReg == IDX_ID);
    strobe.entWr  = winWr && inTable;
    strobe.entHi  = selReg[0];
    strobe.entIdx = entFull[7:0];
    strobe.wdata  = busWdata;
  end
endmodule

// File: rtl/redir_store.sv
module redir_store
  import redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11,
  localparam int        PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  redirStrobe_t             strobe,
  input  logic                     busRdEn,
  input  logic [7:0]               busAddr,
  input  logic [NUM_PINS-1:0]      pendingIn,
  input  logic [NUM_PINS-1:0]      rirrSet,
  input  logic [NUM_PINS-1:0]      rirrClr,
  output logic [31:0]              selReg,
  output logic [31:0]              busRdata,
  output logic [NUM_PINS*64-1:0]   entryFlat,
  output logic                     svcValid,
  output logic [PIN_W-1:0]         svcPin,
  output logic                     maskChgValid,
  output logic [PIN_W-1:0]         maskChgPin,
  output logic                     maskChgVal
);
  localparam logic [63:0] ENT_RESET = 64'(1) << MASK_BIT;
  localparam logic [31:0] RIRR_KEEP = ~(32'(1) << RIRR_BIT);

  logic [NUM_PINS-1:0][63:0] tbl;
  logic [3:0]                idReg;
  logic [NUM_PINS-1:0]       entHit;
  logic [NUM_PINS-1:0]       maskVec;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign entHit[i]              = strobe.entWr && (strobe.entIdx == 8'(i));
    assign maskVec[i]             = tbl[i][MASK_BIT];
    assign entryFlat[64*i +: 64]  = tbl[i];
  end

  // index, identifier and table state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
      for (int i = 0; i < NUM_PINS; i++) tbl[i] <= ENT_RESET;
    end else begin
      if (strobe.selWr) selReg <= strobe.wdata;
      if (strobe.idWr)  idReg  <= strobe.wdata[27:24];
      for (int i = 0; i < NUM_PINS; i++) begin
        if (rirrSet[i]) tbl[i][RIRR_BIT] <= 1'b1;
        if (rirrClr[i]) tbl[i][RIRR_BIT] <= 1'b0;
        if (entHit[i]) begin
          if (strobe.entHi) tbl[i][63:32] <= strobe.wdata;
          else              tbl[i][31:0]  <= strobe.wdata & RIRR_KEEP;
        end
      end
    end
  end

  // event pulses
  logic svcHit;
  logic maskHit;
  always_comb begin
    svcHit  = |(entHit & pendingIn);
    maskHit = !strobe.entHi &&
              |(entHit & (maskVec ^ {NUM_PINS{strobe.wdata[MASK_BIT]}}));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcValid     <= 1'b0;
      svcPin       <= '0;
      maskChgValid <= 1'b0;
      maskChgPin   <= '0;
      maskChgVal   <= 1'b0;
    end else begin
      svcValid     <= svcHit;
      maskChgValid <= maskHit;
      maskChgVal   <= strobe.wdata[MASK_BIT];
      if (strobe.entWr) begin
        svcPin     <= strobe.entIdx[PIN_W-1:0];
        maskChgPin <= strobe.entIdx[PIN_W-1:0];
      end
    end
  end

  // indirect read path
  logic [31:0] rdOfs;
  logic [31:0] rdEnt;
  logic        rdInTbl;
  logic [63:0] rdWord;
  logic [31:0] winData;

  always_comb begin
    rdOfs   = selReg - IDX_TABLE;
    rdEnt   = rdOfs >> 1;
    rdInTbl = (selReg >= IDX_TABLE) && (rdEnt < 32'(NUM_PINS));
    rdWord  = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (rdEnt == 32'(i)) rdWord = tbl[i];
    case (selReg)
      IDX_ID, IDX_ARB: winData = {4'h0, idReg, 24'h0};
      IDX_VER:         winData = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
      default:         winData = !rdInTbl ? 32'h0 :
                                 (selReg[0] ? rdWord[63:32] : rdWord[31:0]);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (busRdEn) begin
      case (busAddr)
        OFS_SELECT: busRdata <= selReg;
        OFS_WINDOW: busRdata <= winData;
        default:    busRdata <= 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/redir_regfile.sv
module redir_regfile
  import redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11,
  localparam int        PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [7:0]              busAddr,
  input  logic [3:0]              busBytes,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  input  logic [NUM_PINS-1:0]     pendingIn,
  input  logic [NUM_PINS-1:0]     rirrSet,
  input  logic [NUM_PINS-1:0]     rirrClr,
  output logic [NUM_PINS*64-1:0]  entryFlat,
  output logic                    svcValid,
  output logic [PIN_W-1:0]        svcPin,
  output logic                    maskChgValid,
  output logic [PIN_W-1:0]        maskChgPin,
  output logic                    maskChgVal
);
  redirStrobe_t strobe;
  logic [31:0]  selReg;

  redir_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .busBytes(busBytes),
    .busWdata(busWdata),
    .selReg  (selReg),
    .strobe  (strobe)
  );

  redir_store #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busRdEn     (busRdEn),
    .busAddr     (busAddr),
    .pendingIn   (pendingIn),
    .rirrSet     (rirrSet),
    .rirrClr     (rirrClr),
    .selReg      (selReg),
    .busRdata    (busRdata),
    .entryFlat   (entryFlat),
    .svcValid    (svcValid),
    .svcPin      (svcPin),
    .maskChgValid(maskChgValid),
    .maskChgPin  (maskChgPin),
    .maskChgVal  (maskChgVal)
  );
endmodule

// File: rtl/redir_regfile_chk.sv
module redir_regfile_chk #(
  parameter int  NUM_PINS = 24,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   entWr,
  input logic                   entHi,
  input logic [7:0]             entIdx,
  input logic [NUM_PINS-1:0]    pendingIn,
  input logic [NUM_PINS-1:0]    rirrSet,
  input logic [NUM_PINS-1:0]    rirrClr,
  input logic [NUM_PINS*64-1:0] entryFlat,
  input logic                   svcValid,
  input logic [PIN_W-1:0]       svcPin,
  input logic                   maskChgValid,
  input logic [PIN_W-1:0]       maskChgPin,
  input logic                   maskChgVal
);
  logic [NUM_PINS-1:0] rirrVec;
  logic [NUM_PINS-1:0] maskVec;
  logic [PIN_W-1:0]    wrPin;
  assign wrPin = entIdx[PIN_W-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    assign rirrVec[i] = entryFlat[64*i + 14];
    assign maskVec[i] = entryFlat[64*i + 16];

    // R10: set without clear or low-word write leaves bit set
    a_r10_set: assert property (@(posedge clk) disable iff (!rstN)
      (rirrSet[i] && !rirrClr[i] && !(entWr && !entHi && entIdx == 8'(i)))
        |=> rirrVec[i]);
    // R10: clear always wins
    a_r10_clr: assert property (@(posedge clk) disable iff (!rstN)
      rirrClr[i] |=> !rirrVec[i]);
  end

  // R7: pending pin written -> service request next cycle
  a_r7_service: assert property (@(posedge clk) disable iff (!rstN)
    (entWr && pendingIn[wrPin]) |=> (svcValid && svcPin == $past(wrPin)));
  // R7: no entry write -> no request
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !entWr |=> !svcValid);
  // R6: low-word write clears remote-IRR
  a_r6_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    (entWr && !entHi) |=> !rirrVec[$past(wrPin)]);
  // R11: strobe carries the stored mask value
  a_r11_mask_strobe: assert property (@(posedge clk) disable iff (!rstN)
    maskChgValid |-> (maskVec[maskChgPin] == maskChgVal));
endmodule

bind redir_regfile redir_regfile_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .entWr       (strobe.entWr),
  .entHi       (strobe.entHi),
  .entIdx      (strobe.entIdx),
  .pendingIn   (pendingIn),
  .rirrSet     (rirrSet),
  .rirrClr     (rirrClr),
  .entryFlat   (entryFlat),
  .svcValid    (svcValid),
  .svcPin      (svcPin),
  .maskChgValid(maskChgValid),
  .maskChgPin  (maskChgPin),
  .maskChgVal  (maskChgVal)
);

// File: tb/test_redir_regfile.sv
module test_redir_regfile;
  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]        busAddr = '0;
  logic [3:0]        busBytes = 4'd4;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NP-1:0]     pendingIn = '0, rirrSet = '0, rirrClr = '0;
  logic [NP*64-1:0]  entryFlat;
  logic              svcValid, maskChgValid, maskChgVal;
  logic [4:0]        svcPin, maskChgPin;

  redir_regfile i_redir_regfile (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] expT [NP];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] n);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d; busBytes = n;
    @(negedge clk);
    busWrEn = 1'b0; busBytes = 4'd4;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdata;
  endtask

  task automatic rdIdx(logic [31:0] idx, output logic [31:0] d);
    wr(8'h00, idx, 4'd4);
    rd(8'h10, d);
  endtask

  task automatic chkTable(string tag);
    for (int p = 0; p < NP; p++) chk(tag, entryFlat[64*p +: 64], expT[p]);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    finish();
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic prevMask;
    for (int p = 0; p < NP; p++) expT[p] = 64'h1_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8 reset state
    rd(8'h00, d); chk("R8 select", d, 0);
    rdIdx(0, d);  chk("R8 id", d, 0);
    chkTable("R8 entries");
    for (int p = 0; p < NP; p++) begin
      rdIdx(32'h10 + 2*p, d); chk("R8 lo", d, 32'h0001_0000);
    end

    // R1 select and unmapped offsets
    wr(8'h00, 32'hDEAD_005A, 4'd4); rd(8'h00, d); chk("R1 select", d, 32'hDEAD_005A);
    rd(8'h20, d); chk("R1 other", d, 0);
    rd(8'h04, d); chk("R1 other2", d, 0);

    // R2 id, R4 arb, R3 version
    wr(8'h00, 0, 4'd4); wr(8'h10, 32'hFFFF_FFFF, 4'd4);
    rd(8'h10, d); chk("R2 id", d, 32'h0F00_0000);
    rdIdx(2, d); chk("R4 arb", d, 32'h0F00_0000);
    wr(8'h10, 0, 4'd4); rdIdx(0, d); chk("R4 arb write ignored", d, 32'h0F00_0000);
    rdIdx(1, d); chk("R3 version", d, ((NP - 1) << 16) | 32'h11);
    wr(8'h10, 32'h1234_5678, 4'd4); rd(8'h10, d); chk("R3 write ignored", d, ((NP - 1) << 16) | 32'h11);

    // R9 size filtering
    wr(8'h00, 0, 4'd4);
    wr(8'h10, 32'h0300_0000, 4'd2); rd(8'h10, d); chk("R9 size2", d, 32'h0F00_0000);
    wr(8'h10, 32'h0300_0000, 4'd8); rd(8'h10, d); chk("R9 size8", d, 32'h0300_0000);
    wr(8'h00, 32'h5, 4'd1); rd(8'h00, d); chk("R9 select size1", d, 0);

    // R5 R12 R11 sweep over every pin
    for (int p = 0; p < NP; p++) begin
      lo = (p * 32'h9E37_79B1) | 32'h4000;
      hi = (p * 32'h0100_0001) ^ 32'hA500_0000;
      prevMask = expT[p][16];
      wr(8'h00, 32'h10 + 2*p + 1, 4'd4); wr(8'h10, hi, 4'd4);
      expT[p][63:32] = hi;
      wr(8'h00, 32'h10 + 2*p, 4'd4); wr(8'h10, lo, 4'd4);
      expT[p][31:0] = lo & ~32'h4000;
      chk("R11 strobe", {maskChgValid}, {lo[16] != prevMask});
      if (lo[16] != prevMask) chk("R11 pin/val", {maskChgPin, maskChgVal}, {5'(p), lo[16]});
      chk("R7 no service", {svcValid}, 0);
      rd(8'h10, d); chk("R5 R6 lo", d, expT[p][31:0]);
      rdIdx(32'h10 + 2*p + 1, d); chk("R5 hi", d, hi);
    end
    chkTable("R12 layout");

    // R5 out of range
    wr(8'h00, 32'h10 + 2*NP, 4'd4); wr(8'h10, 32'hFFFF_FFFF, 4'd4);
    rd(8'h10, d); chk("R5 oor read", d, 0);
    chkTable("R5 oor write dropped");
    rdIdx(5, d); chk("R5 gap read", d, 0);

    // R7 service request
    pendingIn = NP'(1) << 7;
    wr(8'h00, 32'h10 + 15, 4'd4); wr(8'h10, 32'h1100_0000, 4'd4);
    expT[7][63:32] = 32'h1100_0000;
    chk("R7 service", {svcValid, svcPin}, {1'b1, 5'd7});
    @(negedge clk); chk("R7 single pulse", {svcValid}, 0);
    wr(8'h00, 32'h10 + 16, 4'd4); wr(8'h10, 32'h0000_0021, 4'd4);
    expT[8][31:0] = 32'h21;
    chk("R7 not pending", {svcValid}, 0);
    pendingIn = '0;

    // R10 R6 remote-IRR port
    @(negedge clk); rirrSet = NP'(1) << 3; @(negedge clk); rirrSet = '0;
    expT[3][14] = 1'b1;
    chk("R10 set", entryFlat[64*3 +: 64], expT[3]);
    wr(8'h00, 32'h10 + 6, 4'd4); rd(8'h10, d); chk("R10 read rirr", d, expT[3][31:0]);
    wr(8'h00, 32'h10 + 7, 4'd4); wr(8'h10, 32'h4400_0000, 4'd4);
    expT[3][63:32] = 32'h4400_0000;
    chk("R6 hi keeps", entryFlat[64*3 +: 64], expT[3]);
    wr(8'h00, 32'h10 + 6, 4'd4); wr(8'h10, 32'h0001_C033, 4'd4);
    expT[3][31:0] = 32'h0001_8033;
    chk("R6 lo clears", entryFlat[64*3 +: 64], expT[3]);
    @(negedge clk); rirrSet = NP'(1) << 3; rirrClr = NP'(1) << 3;
    @(negedge clk); rirrSet = '0; rirrClr = '0;
    chk("R10 clear wins", entryFlat[64*3 +: 64], expT[3]);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'h10; busWdata = 32'h0001_0044; rirrSet = NP'(1) << 3;
    @(negedge clk); busWrEn = 1'b0; rirrSet = '0;
    expT[3][31:0] = 32'h0001_0044;
    chk("R10 write beats set", entryFlat[64*3 +: 64], expT[3]);
    chkTable("R12 final");
    finish();
  end
endmodule